// File: doc/BRIEF.md
# Miss-Side Load Value Predictor

This block sits next to a second-level cache and deals only with loads that miss there. When a miss is presented, it reads a last-value table indexed by the low bits of the load's PC. It returns the stored value and a confidence flag to the core on the following cycle, long before memory answers. The value handed out is kept in one of a small set of outstanding-miss slots, together with the miss tag and the table index it came from.

When the memory fill for that tag arrives, the block compares the real data with the value it recorded at miss time. It emits a one-cycle validation pulse carrying the tag and a match bit, then retrains the table entry. Cache hits never reach the block, so it stays off the core's critical path and learns only from miss traffic. The consumer uses the confidence flag to decide how much speculative work to risk on each prediction.

Top module: `lvp_top`

## Requirements
- R1: A miss accepted in cycle t (missValid=1 and missReady=1) produces predValid=1 for exactly one cycle in cycle t+1, with predTag equal to the miss tag and predData equal to the value stored in table entry missIndex at cycle t.
- R2: During and right after reset, predValid=0, valValid=0 and missReady=1. Every table entry holds value 0 with confidence 0, and no miss is outstanding.
- R3: A fill in cycle t whose tag equals the tag of an outstanding miss produces valValid=1 for exactly one cycle in cycle t+1, with valTag equal to the fill tag. valMatch=1 when the fill data equals the recorded prediction, and 0 otherwise. The fill retires that miss.
- R4: Each table entry holds a value and a 2-bit confidence counter. predHighConf=1 exactly when the counter is 2 or more. A matching fill raises the counter by one, saturating at 3. A mismatching fill clears it to 0. In both cases the stored value becomes the fill data.
- R5: At most 8 misses are outstanding. missReady=0 exactly when 8 are outstanding. A miss presented while missReady=0 gets no prediction and takes no slot.
- R6: A fill whose tag matches no outstanding miss raises no validation pulse and leaves the table unchanged.
- R7: When a miss and a fill arrive in the same cycle, the miss reads the table contents from before that fill's training. A slot freed by that fill cannot be taken by a miss until the next cycle.
- R8: A fill is compared against the value recorded for its own miss, even if the table entry was retrained after that miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A second-level miss is presented this cycle |
| missIndex | input | 8 | Low PC bits of the missing load, used as table index |
| missTag | input | 4 | Identifier of the miss, unique among outstanding misses |
| missReady | output | 1 | A slot is free, so a presented miss is accepted |
| predValid | output | 1 | Prediction response valid |
| predTag | output | 4 | Tag of the miss being answered |
| predData | output | 32 | Predicted load value |
| predHighConf | output | 1 | Prediction has high confidence |
| fillValid | input | 1 | Memory data for a miss arrives this cycle |
| fillTag | input | 4 | Tag of the returning miss |
| fillData | input | 32 | Real memory value |
| valValid | output | 1 | One-cycle validation pulse |
| valTag | output | 4 | Tag of the validated miss |
| valMatch | output | 1 | Prediction equalled the real value |

## Verification
A wrong counter or stored value in the table stays hidden until that index is missed again. It then shows one cycle later as a wrong predData or predHighConf. So the stimulus reuses a small set of indices, making every training step show up within a few cycles. A corrupt slot (wrong recorded value, tag or occupancy) shows as a wrong valMatch, a missing or extra validation pulse one cycle after the fill, or a missReady level that disagrees with the count of outstanding misses in the very same cycle.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  // Number of outstanding-miss slots; the strobe struct is sized from it.
  localparam int SlotCount = 8;

  typedef struct packed {
    logic                 accept;   // miss accepted this cycle
    logic [SlotCount-1:0] allocOh;  // slot that the miss takes (one-hot)
    logic                 fillHit;  // fill matched an outstanding slot
    logic [SlotCount-1:0] fillOh;   // slot retired by the fill (one-hot)
  } lvpStrobes_t;
endpackage

// File: rtl/lvp_ctrl.sv
module lvp_ctrl
  import lvp_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             missValid,
  input  logic [TAG_W-1:0] missTag,
  input  logic             fillValid,
  input  logic [TAG_W-1:0] fillTag,
  output logic             missReady,
  output lvpStrobes_t      strb
);
  localparam int SLOTS = SlotCount;

  logic [SLOTS-1:0] slotValid;
  logic [TAG_W-1:0] slotTag [SLOTS];
  logic [SLOTS-1:0] hitVec;
  logic [SLOTS-1:0] freeVec;
  logic [SLOTS-1:0] allocOh;
  logic [SLOTS-1:0] fillOh;

  // Tag compare across all slots in parallel.
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      hitVec[i] = fillValid && slotValid[i] && (slotTag[i] == fillTag);
    end
  end

  assign freeVec   = ~slotValid;
  assign missReady = |freeVec;
  // Lowest free slot and lowest hitting slot, isolated by x & -x.
  assign allocOh   = missValid ? (freeVec & (~freeVec + 1'b1)) : '0;
  assign fillOh    = hitVec & (~hitVec + 1'b1);

  always_comb begin
    strb         = '0;
    strb.accept  = missValid && missReady;
    strb.allocOh = allocOh;
    strb.fillHit = |fillOh;
    strb.fillOh  = fillOh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      for (int i = 0; i < SLOTS; i++) slotTag[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (allocOh[i]) begin
          slotValid[i] <= 1'b1;
          slotTag[i]   <= missTag;
        end else if (fillOh[i]) begin
          slotValid[i] <= 1'b0;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!missReady && !strb.fillHit) |=> !missReady); // R5
  AST_FREE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (!missReady && strb.fillHit) |=> missReady); // R7
endmodule

// File: rtl/lvp_datapath.sv
module lvp_datapath
  import lvp_pkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int CONF_W  = 2,
  parameter int CONF_HI = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  missIndex,
  input  logic [TAG_W-1:0]  missTag,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [DATA_W-1:0] fillData,
  input  lvpStrobes_t       strb,
  output logic              predValid,
  output logic [TAG_W-1:0]  predTag,
  output logic [DATA_W-1:0] predData,
  output logic              predHighConf,
  output logic              valValid,
  output logic [TAG_W-1:0]  valTag,
  output logic              valMatch
);
  localparam int SLOTS   = SlotCount;
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_THR = CONF_W'(CONF_HI);

  logic [DATA_W-1:0] tblValue [ENTRIES];
  logic [CONF_W-1:0] tblConf  [ENTRIES];
  logic [DATA_W-1:0] slotPred [SLOTS];
  logic [IDX_W-1:0]  slotIdx  [SLOTS];

  logic [DATA_W-1:0] readValue;
  logic [CONF_W-1:0] readConf;
  logic [DATA_W-1:0] selPred;
  logic [IDX_W-1:0]  selIdx;
  logic              isMatch;
  logic [CONF_W-1:0] confOld;
  logic [CONF_W-1:0] confNew;

  assign readValue = tblValue[missIndex];
  assign readConf  = tblConf[missIndex];

  // Gather the recorded prediction of the retiring slot.
  always_comb begin
    selPred = '0;
    selIdx  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (strb.fillOh[i]) begin
        selPred = selPred | slotPred[i];
        selIdx  = selIdx | slotIdx[i];
      end
    end
  end

  assign isMatch = (fillData == selPred);
  assign confOld = tblConf[selIdx];
  assign confNew = !isMatch ? '0 : ((confOld == CONF_MAX) ? CONF_MAX : confOld + 1'b1);

  // Prediction table: trained only by fills that retire a slot.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tblValue[e] <= '0;
        tblConf[e]  <= '0;
      end
    end else if (strb.fillHit) begin
      tblValue[selIdx] <= fillData;
      tblConf[selIdx]  <= confNew;
    end
  end

  // Per-miss record of what was predicted and where it came from.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        slotPred[i] <= '0;
        slotIdx[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (strb.allocOh[i]) begin
          slotPred[i] <= readValue;
          slotIdx[i]  <= missIndex;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid    <= 1'b0;
      predTag      <= '0;
      predData     <= '0;
      predHighConf <= 1'b0;
      valValid     <= 1'b0;
      valTag       <= '0;
      valMatch     <= 1'b0;
    end else begin
      predValid    <= strb.accept;
      predTag      <= missTag;
      predData     <= readValue;
      predHighConf <= (readConf >= CONF_THR);
      valValid     <= strb.fillHit;
      valTag       <= fillTag;
      valMatch     <= isMatch;
    end
  end

  AST_PRED_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> $past(strb.accept)); // R1
  AST_VAL_AFTER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    valValid |-> $past(strb.fillHit)); // R6
endmodule

// File: rtl/lvp_top.sv
module lvp_top
  import lvp_pkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 8,
  parameter int CONF_W  = 2,
  parameter int CONF_HI = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [IDX_W-1:0]  missIndex,
  input  logic [TAG_W-1:0]  missTag,
  output logic              missReady,
  output logic              predValid,
  output logic [TAG_W-1:0]  predTag,
  output logic [DATA_W-1:0] predData,
  output logic              predHighConf,
  input  logic              fillValid,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [DATA_W-1:0] fillData,
  output logic              valValid,
  output logic [TAG_W-1:0]  valTag,
  output logic              valMatch
);
  lvpStrobes_t strb;

  lvp_ctrl #(.TAG_W(TAG_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missTag(missTag),
    .fillValid(fillValid), .fillTag(fillTag),
    .missReady(missReady), .strb(strb)
  );

  lvp_datapath #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .CONF_W(CONF_W), .CONF_HI(CONF_HI)
  ) uData (
    .clk(clk), .rstN(rstN),
    .missIndex(missIndex), .missTag(missTag),
    .fillTag(fillTag), .fillData(fillData), .strb(strb),
    .predValid(predValid), .predTag(predTag), .predData(predData),
    .predHighConf(predHighConf),
    .valValid(valValid), .valTag(valTag), .valMatch(valMatch)
  );

  AST_PRED_TAG: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> ($past(missValid) && predTag == $past(missTag))); // R1
  AST_PRED_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> $past(missReady)); // R5
  AST_VAL_TAG: assert property (@(posedge clk) disable iff (!rstN)
    valValid |-> ($past(fillValid) && valTag == $past(fillTag))); // R3
endmodule

// File: tb/tb_lvp_top.sv
`timescale 1ns/1ps
module tb_lvp_top;
  localparam int TW = 4;
  localparam int DW = 32;
  localparam int IW = 8;
  localparam int NS = 8;
  localparam int NE = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic missValid = 1'b0;
  logic [IW-1:0] missIndex = '0;
  logic [TW-1:0] missTag = '0;
  logic fillValid = 1'b0;
  logic [TW-1:0] fillTag = '0;
  logic [DW-1:0] fillData = '0;
  logic missReady, predValid, predHighConf, valValid, valMatch;
  logic [TW-1:0] predTag, valTag;
  logic [DW-1:0] predData;

  lvp_top dut (
    .clk(clk), .rstN(rstN),
    .missValid(missValid), .missIndex(missIndex), .missTag(missTag),
    .missReady(missReady),
    .predValid(predValid), .predTag(predTag), .predData(predData),
    .predHighConf(predHighConf),
    .fillValid(fillValid), .fillTag(fillTag), .fillData(fillData),
    .valValid(valValid), .valTag(valTag), .valMatch(valMatch)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // Reference model state
  logic [DW-1:0] mVal [NE];
  logic [1:0]    mConf [NE];
  logic          sV [NS];
  logic [TW-1:0] sT [NS];
  logic [DW-1:0] sP [NS];
  logic [IW-1:0] sI [NS];

  logic ePV = 1'b0, ePH = 1'b0, eVV = 1'b0, eVM = 1'b0;
  logic [TW-1:0] ePT = '0, eVT = '0;
  logic [DW-1:0] ePD = '0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int busyCount();
    int c = 0;
    for (int k = 0; k < NS; k++) if (sV[k]) c++;
    return c;
  endfunction

  function automatic bit tagBusy(input logic [TW-1:0] t);
    for (int k = 0; k < NS; k++) if (sV[k] && sT[k] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input logic mv, input logic [IW-1:0] mi, input logic [TW-1:0] mt,
                      input logic fv, input logic [TW-1:0] ft, input logic [DW-1:0] fd);
    int allocSlot;
    int hit;
    bit accept;
    @(negedge clk);
    // Results of the previous cycle's stimulus
    chk("R1/R5", "predValid", predValid, ePV);
    if (ePV) begin
      chk("R1", "predTag", predTag, ePT);
      chk("R1/R4", "predData", predData, ePD);
      chk("R4", "predHighConf", predHighConf, ePH);
    end
    chk("R3/R6", "valValid", valValid, eVV);
    if (eVV) begin
      chk("R3", "valTag", valTag, eVT);
      chk("R3/R8", "valMatch", valMatch, eVM);
    end
    chk("R5", "missReady", missReady, busyCount() < NS);

    missValid = mv; missIndex = mi; missTag = mt;
    fillValid = fv; fillTag = ft; fillData = fd;

    // R7: the miss sees the table before this cycle's training, and
    // the slot a fill frees is not available to it.
    accept = mv && (busyCount() < NS);
    ePV = accept; ePT = mt; ePD = mVal[mi]; ePH = (mConf[mi] >= 2);
    allocSlot = -1;
    if (accept) begin
      for (int k = NS - 1; k >= 0; k--) if (!sV[k]) allocSlot = k;
    end
    hit = -1;
    if (fv) begin
      for (int k = NS - 1; k >= 0; k--) if (sV[k] && sT[k] == ft) hit = k;
    end
    eVV = (hit >= 0);
    if (hit >= 0) begin
      eVT = ft;
      eVM = (fd == sP[hit]);  // R8: recorded value, not current table
      mVal[sI[hit]] = fd;
      if (eVM) mConf[sI[hit]] = (mConf[sI[hit]] == 2'd3) ? 2'd3 : mConf[sI[hit]] + 2'd1;
      else     mConf[sI[hit]] = 2'd0;
      sV[hit] = 1'b0;
    end
    if (allocSlot >= 0) begin
      sV[allocSlot] = 1'b1; sT[allocSlot] = mt;
      sP[allocSlot] = ePD;  sI[allocSlot] = mi;
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic mv, fv;
    logic [IW-1:0] mi;
    logic [TW-1:0] mt, ft;
    logic [DW-1:0] fd;
    void'($urandom(32'd4021));
    for (int e = 0; e < NE; e++) begin mVal[e] = '0; mConf[e] = '0; end
    for (int k = 0; k < NS; k++) begin sV[k] = 0; sT[k] = '0; sP[k] = '0; sI[k] = '0; end

    repeat (4) @(negedge clk);
    // R2: reset state
    chk("R2", "predValid", predValid, 0);
    chk("R2", "valValid", valValid, 0);
    chk("R2", "missReady", missReady, 1);
    rstN = 1'b1;

    // R4: train entry 5 up to high confidence, then break it
    step(1, 8'd5, 4'd1, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd1, 32'd0);
    step(1, 8'd5, 4'd2, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd2, 32'd0);
    step(1, 8'd5, 4'd3, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd3, 32'd7);
    // R6: stray fill, then entry 5 must still read 7 at low confidence
    step(0, 8'd0, 4'd0, 1, 4'hE, 32'hDEAD);
    step(1, 8'd5, 4'd4, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd4, 32'd7);
    // R8: two misses on one entry, retrain between their fills
    step(1, 8'd9, 4'd5, 0, 4'd0, 32'd0);
    step(1, 8'd9, 4'd6, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd5, 32'h11);
    step(0, 8'd0, 4'd0, 1, 4'd6, 32'd0);
    // R7: miss and training fill on the same entry in one cycle
    step(1, 8'd9, 4'd8, 0, 4'd0, 32'd0);
    step(1, 8'd9, 4'd9, 1, 4'd8, 32'h22);
    step(0, 8'd0, 4'd0, 1, 4'd9, 32'h22);
    step(1, 8'd9, 4'd10, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd10, 32'h22);
    // R5: fill all slots, then reject misses, including one beside a fill
    for (int k = 0; k < NS; k++) step(1, IW'(k), TW'(k), 0, 4'd0, 32'd0);
    step(1, 8'd1, 4'd12, 0, 4'd0, 32'd0);
    step(1, 8'd1, 4'd13, 1, 4'd0, 32'd3);
    step(1, 8'd1, 4'd14, 0, 4'd0, 32'd0);
    for (int k = 1; k < NS; k++) step(0, 8'd0, 4'd0, 1, TW'(k), 32'd0);
    step(0, 8'd0, 4'd0, 1, 4'd14, 32'd0);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      mv = (($urandom % 3) != 0);
      mt = TW'($urandom % 16);
      if (tagBusy(mt)) mv = 1'b0;
      mi = (($urandom % 4) == 0) ? IW'($urandom % 256) : IW'($urandom % 4);
      fv = (($urandom % 2) == 0);
      k = int'($urandom % NS);
      if (sV[k]) begin
        ft = sT[k];
        fd = (($urandom % 2) == 0) ? sP[k] : DW'($urandom % 4);
      end else begin
        ft = TW'($urandom % 16);
        fd = DW'($urandom % 4);
      end
      step(mv, mi, mt, fv, ft, fd);
    end
    step(0, 8'd0, 4'd0, 0, 4'd0, 32'd0);
    step(0, 8'd0, 4'd0, 0, 4'd0, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule